// File: doc/BRIEF.md
# I2C Register-Access Slave

This block is a bus target on a two-wire serial bus with 7-bit addressing. It gives a bus master byte-wide read and write access to a 256-entry internal register array. The upper six bits of the device address are a parameter (default `111000`). The lowest bit comes from a strap input, so two copies can share one bus at addresses 0x70 and 0x71.

The clock and data lines are synchronized into the system clock domain and oversampled there. The system clock must run at least twenty times the bus bit rate, so both 100 kbit/s and 400 kbit/s operation are covered. A write transfer sets an 8-bit register pointer and may then store one or more data bytes, with the pointer stepping by one after each byte. The pointer keeps its value across a STOP. A later read transfer therefore streams bytes from where the pointer was left, again stepping by one per byte.

The data line is driven only low, through an output enable that the pad turns into an open-drain pull-down. A watchdog on the synchronized data line returns the protocol engine to idle and lets go of the line if the line stays low for a parameterized number of system clocks.

Top module: `i2c_regslave`

## Requirements
- R1: The block acknowledges (pulls data low in the ninth clock) an address byte whose upper seven bits equal {fixed six bits, addr_sel} with either direction bit. Any other address is not acknowledged, and the following bytes up to the next START or STOP change no register and draw no drive.
- R2: Every byte moves most-significant bit first. The ninth clock of each byte is the acknowledge: low is ACK, high is NACK.
- R3: In a write transfer (address byte with direction bit 0), the first byte after the address loads the register pointer, and the next byte is stored at that register. The block ACKs every byte.
- R4: Each data byte written or read moves the pointer up by one, wrapping from 0xFF to 0x00, so a burst covers consecutive registers.
- R5: The pointer survives STOP. A read transfer (direction bit 1) returns data starting at the stored pointer.
- R6: During a read, the block keeps sending bytes while the master ACKs. After a master NACK it leaves the data line released, and STOP always releases it.
- R7: The block starts driving the data line only while the clock line is low. It releases the line on the clock fall that ends the acknowledge clock.
- R8: If the synchronized data line stays low for TIMEOUT_CYCLES system clocks, the engine returns to idle and releases the line. The next transfer then works normally.
- R9: A repeated START (START without a STOP before it) restarts address reception at once, which allows a pointer-set followed directly by a read.
- R10: After reset the data line is released, all registers read 0x00 and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the bus bit rate |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | Strap that supplies bit 0 of the device address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
The bench goes after the pointer wrap from 0xFF to 0x00 and its persistence across STOP. A design that saturated or cleared the pointer would return the wrong byte on the following pointer-less read. Foreign addresses are followed by data bytes that must leave the array untouched, which catches a block that keeps decoding after a mismatch. A repeated START straight into a read, and a master NACK ending a burst, expose engines that wait for STOP or keep driving. A stalled acknowledge clock must be cut off by the timeout, and a design without working recovery would hold the bus low forever or fail the transfer that follows.

// File: rtl/i2c_regslave_pkg.sv
package i2c_regslave_pkg;

    localparam int unsigned REG_AW = 8;
    localparam int unsigned DATA_W = 8;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [REG_AW-1:0] regaddr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WR,
        ST_ACK,
        ST_RD,
        ST_RD_ACK
    } bus_state_e;

    // Synchronized line levels and single-cycle bus events
    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic addr_hit(input byte_t rx, input logic [5:0] fixed_hi,
                                      input logic lsb);
        return rx[7:1] == {fixed_hi, lsb};
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_regslave_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int unsigned TOP = STAGES - 1;

    logic [1:0] line_in;
    logic [1:0] line_now;
    logic [1:0] line_old;

    assign line_in = {scl_in, sda_in};

    // One synchronizer chain per bus line
    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) begin
                pipe        <= '1;
                line_old[g] <= 1'b1;
            end else begin
                pipe        <= {pipe[STAGES-2:0], line_in[g]};
                line_old[g] <= pipe[TOP];
            end
        end
        assign line_now[g] = pipe[TOP];
    end

    always_comb begin
        ev.scl      = line_now[1];
        ev.sda      = line_now[0];
        ev.scl_rise = line_now[1] & ~line_old[1];
        ev.scl_fall = ~line_now[1] & line_old[1];
        ev.start    = line_now[1] & line_old[1] & line_old[0] & ~line_now[0];
        ev.stop     = line_now[1] & line_old[1] & ~line_old[0] & line_now[0];
    end

endmodule

// File: rtl/i2c_sda_watch.sv
module i2c_sda_watch #(
    parameter int unsigned LIMIT = 3125000
) (
    input  logic clk,
    input  logic rst,
    input  logic sda_low,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !sda_low) begin
            cnt <= '0;
        end else if (cnt != CW'(LIMIT)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Single pulse when the low stretch reaches the limit
    assign expired = sda_low && (cnt == CW'(LIMIT - 1));

    // R8
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(LIMIT));

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);

endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/i2c_regslave.sv
module i2c_regslave
    import i2c_regslave_pkg::*;
#(
    parameter logic [5:0]  DEV_ADDR_HI    = 6'b111000,
    parameter int unsigned TIMEOUT_CYCLES = 3125000,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic addr_sel,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    bus_ev_t    ev;
    logic       expired;
    bus_state_e state;
    bus_state_e ack_next;
    logic [2:0] cnt;
    logic       bit_done;
    byte_t      sh;
    regaddr_t   ptr;
    byte_t      rdata;
    logic       master_ack;
    logic       wr_fire;
    logic       quiet;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_i),
        .sda_in (sda_i),
        .ev     (ev)
    );

    i2c_sda_watch #(.LIMIT(TIMEOUT_CYCLES)) u_watch (
        .clk     (clk),
        .rst     (rst),
        .sda_low (~ev.sda),
        .expired (expired)
    );

    i2c_reg_array #(.AW(REG_AW), .DW(DATA_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_fire),
        .waddr (ptr),
        .wdata (sh),
        .raddr (ptr),
        .rdata (rdata)
    );

    // No overriding bus event this cycle
    assign quiet   = !expired && !ev.stop && !ev.start;
    assign wr_fire = quiet && (state == ST_WR) && ev.scl_fall && bit_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            ack_next   <= ST_IDLE;
            sda_oe     <= 1'b0;
            cnt        <= '0;
            bit_done   <= 1'b0;
            sh         <= '0;
            ptr        <= '0;
            master_ack <= 1'b0;
        end else if (expired || ev.stop) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
        end else if (ev.start) begin
            state    <= ST_ADDR;
            sda_oe   <= 1'b0;
            cnt      <= '0;
            bit_done <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_PTR, ST_WR: begin
                    if (ev.scl_rise) begin
                        sh       <= {sh[6:0], ev.sda};
                        cnt      <= cnt + 1'b1;
                        bit_done <= (cnt == 3'd7);
                    end else if (ev.scl_fall && bit_done) begin
                        bit_done <= 1'b0;
                        cnt      <= '0;
                        if (state == ST_ADDR) begin
                            if (addr_hit(sh, DEV_ADDR_HI, addr_sel)) begin
                                sda_oe   <= 1'b1;
                                ack_next <= sh[0] ? ST_RD : ST_PTR;
                                state    <= ST_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            if (state == ST_PTR) begin
                                ptr <= sh;
                            end else begin
                                ptr <= ptr + 1'b1;
                            end
                            sda_oe   <= 1'b1;
                            ack_next <= ST_WR;
                            state    <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        if (ack_next == ST_RD) begin
                            sh     <= rdata;
                            ptr    <= ptr + 1'b1;
                            sda_oe <= ~rdata[7];
                            cnt    <= '0;
                        end else begin
                            sda_oe <= 1'b0;
                        end
                        state <= ack_next;
                    end
                end
                ST_RD: begin
                    if (ev.scl_fall) begin
                        if (cnt == 3'd7) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RD_ACK;
                        end else begin
                            cnt    <= cnt + 1'b1;
                            sh     <= {sh[6:0], 1'b0};
                            sda_oe <= ~sh[6];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev.scl_rise) begin
                        master_ack <= ~ev.sda;
                    end else if (ev.scl_fall) begin
                        if (master_ack) begin
                            sh     <= rdata;
                            ptr    <= ptr + 1'b1;
                            sda_oe <= ~rdata[7];
                            cnt    <= '0;
                            state  <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    drive_on_low_clk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    // R8
    timeout_release_chk: assert property (@(posedge clk) disable iff (rst)
        expired |=> (!sda_oe && state == ST_IDLE));

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
        wr_fire |=> ptr == regaddr_t'($past(ptr) + 1'b1));

    // R6
    nack_release_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RD_ACK && ev.scl_fall && !master_ack && quiet) |=> !sda_oe);

endmodule

// File: tb/tb_i2c_regslave.sv
module tb_i2c_regslave;

    localparam int Q  = 10;
    localparam int TO = 5000;

    // {register, data} pairs for write-then-read-back
    localparam logic [15:0] VEC [0:7] = '{
        16'h00_3C, 16'h01_A5, 16'h10_FF, 16'h7F_00,
        16'h80_81, 16'hC3_5A, 16'h42_E7, 16'h20_01
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic addr_sel = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic bus_sda;

    int checks = 0;
    int errors = 0;
    int r7_bad = 0;
    logic oe_prev = 1'b0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    assign bus_sda = m_sda & ~sda_oe;

    i2c_regslave #(.TIMEOUT_CYCLES(TO)) dut (
        .clk      (clk),
        .rst      (rst),
        .addr_sel (addr_sel),
        .scl_i    (m_scl),
        .sda_i    (bus_sda),
        .sda_oe   (sda_oe)
    );

    // R7 monitor: the drive may change only while the clock line is low
    always @(negedge clk) begin
        if (!rst && (sda_oe !== oe_prev) && m_scl) r7_bad++;
        oe_prev <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic bus_start;
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        m_sda = b;    tick(Q);
        m_scl = 1'b1; tick(Q);
        seen = bus_sda; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            b[i] = s;
        end
        clock_bit(~give_ack, s);
    endtask

    task automatic write_one(input logic [6:0] dev, input logic [7:0] r,
                             input logic [7:0] d, output logic [2:0] acks);
        bus_start;
        send_byte({dev, 1'b0}, acks[2]);
        send_byte(r, acks[1]);
        send_byte(d, acks[0]);
        bus_stop;
    endtask

    task automatic set_ptr(input logic [6:0] dev, input logic [7:0] r, output logic [1:0] acks);
        bus_start;
        send_byte({dev, 1'b0}, acks[1]);
        send_byte(r, acks[0]);
        bus_stop;
    endtask

    task automatic read_one(input logic [6:0] dev, output logic ack, output logic [7:0] d);
        bus_start;
        send_byte({dev, 1'b1}, ack);
        recv_byte(1'b0, d);
        bus_stop;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] a3;
        logic [1:0] a2;
        logic       a1;
        logic [7:0] d;

        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        tick(4);

        // R10: released line, pointer and registers cleared
        check("R10 sda_oe after reset", {7'b0, sda_oe}, 8'h00);
        read_one(7'h70, a1, d);
        check("R10 ack on read", {7'b0, a1}, 8'h01);
        check("R10 reg0 via reset pointer", d, 8'h00);

        // R2 R3 R5: table of write / two-stage read-back
        for (int i = 0; i < 8; i++) begin
            write_one(7'h70, VEC[i][15:8], VEC[i][7:0], a3);
            check("R3 write acks", {5'b0, a3}, 8'h07);
            model[VEC[i][15:8]] = VEC[i][7:0];
            set_ptr(7'h70, VEC[i][15:8], a2);
            check("R5 pointer-set acks", {6'b0, a2}, 8'h03);
            read_one(7'h70, a1, d);
            check("R2 R5 read-back", d, model[VEC[i][15:8]]);
        end

        // R1: foreign address is not acknowledged and changes nothing
        write_one(7'h72, 8'h01, 8'h99, a3);
        check("R1 foreign address ack", {5'b0, a3}, 8'h00);
        set_ptr(7'h70, 8'h01, a2);
        read_one(7'h70, a1, d);
        check("R1 reg01 untouched", d, model[8'h01]);

        // R1: strap selects the low address bit
        addr_sel = 1'b1;
        write_one(7'h70, 8'h55, 8'h66, a3);
        check("R1 0x70 ignored when strap high", {5'b0, a3}, 8'h00);
        write_one(7'h71, 8'h55, 8'h77, a3);
        check("R1 0x71 acked when strap high", {5'b0, a3}, 8'h07);
        model[8'h55] = 8'h77;
        set_ptr(7'h71, 8'h55, a2);
        read_one(7'h71, a1, d);
        check("R1 strap-high read-back", d, 8'h77);
        addr_sel = 1'b0;

        // R4: burst write across the top of the register space
        bus_start;
        send_byte(8'hE0, a1);
        send_byte(8'hFE, a1);
        send_byte(8'h11, a1);
        send_byte(8'h22, a1);
        send_byte(8'h33, a1);
        check("R4 last burst byte acked", {7'b0, a1}, 8'h01);
        bus_stop;
        model[8'hFE] = 8'h11; model[8'hFF] = 8'h22; model[8'h00] = 8'h33;

        // R5: pointer kept across STOP, now 0x01 after the wrap
        read_one(7'h70, a1, d);
        check("R5 pointer persisted after wrap", d, model[8'h01]);

        // R4 R6: read burst with ACK, ACK, NACK
        set_ptr(7'h70, 8'hFE, a2);
        bus_start;
        send_byte(8'hE1, a1);
        recv_byte(1'b1, d);
        check("R6 burst byte 0", d, 8'h11);
        recv_byte(1'b1, d);
        check("R4 burst byte 1", d, 8'h22);
        recv_byte(1'b0, d);
        check("R4 burst byte 2 after wrap", d, 8'h33);
        check("R6 released after NACK", {7'b0, sda_oe}, 8'h00);
        bus_stop;

        // R9: repeated START from pointer-set straight into a read
        bus_start;
        send_byte(8'hE0, a1);
        send_byte(8'h10, a1);
        bus_start;
        send_byte(8'hE1, a1);
        check("R9 ack after repeated start", {7'b0, a1}, 8'h01);
        recv_byte(1'b0, d);
        bus_stop;
        check("R9 data after repeated start", d, model[8'h10]);

        // R8: master stalls in the acknowledge clock
        bus_start;
        for (int i = 7; i >= 0; i--) clock_bit(((8'hE0 >> i) & 8'h01) != 0, a1);
        m_sda = 1'b1;
        tick(Q);
        check("R8 holding ACK before timeout", {7'b0, sda_oe}, 8'h01);
        tick(TO + 40);
        check("R8 released after timeout", {7'b0, sda_oe}, 8'h00);
        bus_stop;
        write_one(7'h70, 8'h30, 8'hC4, a3);
        check("R8 write after recovery", {5'b0, a3}, 8'h07);
        model[8'h30] = 8'hC4;
        set_ptr(7'h70, 8'h30, a2);
        read_one(7'h70, a1, d);
        check("R8 read after recovery", d, 8'hC4);

        // R7: no drive change seen while the clock line was high
        check("R7 drive changes outside low clock", r7_bad[7:0], 8'h00);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule